// File: doc/BRIEF.md
# Pair-HMM Forward Recursion Cell

This block evaluates one cell of the three forward-algorithm matrices (match, insert, delete) used to score how well a sequencing read aligns to a candidate haplotype. For a cell it receives the diagonal, upper and left neighbour values. It also receives the two bases being compared and four per-position quality probabilities: base error, insertion gap open, deletion gap open and gap continuation. From these it forms the emission prior and the seven transition probabilities, and it returns the three new matrix values. It also returns their saturated sum, so the scheduler can read the final likelihood when it issues the last cell of a pair.

All probabilities are unsigned 16-bit fractions in which all-ones stands for one. Every product keeps its upper 16 bits, which is a truncation. Every sum clamps at all-ones. Two flags mark cells in the first row and the first column, where fixed boundary values replace the recursion. A build-time option selects a retimed match path. In that variant, the scheduler supplies two partial terms that it formed one cell earlier, and the block adds them and multiplies by the prior.

Cells enter and leave through valid/ready streams, and the block holds an opaque tag alongside each cell. The pipeline is DEPTH registers long and advances as a whole whenever the output register is empty or is being taken. `in_ready` is exactly that advance condition. When the output holds a cell and `out_ready` is low, nothing moves, the output stays unchanged and no input is taken. With `out_ready` held high, one cell can enter every cycle.

Top module: `phmm_fwd_cell`

## Requirements
- R1: Match output = trunc(prior × sat(sat(amm×m_diag + aim×i_diag) + adm×d_diag)). Every product a×b is (a·b)>>16, and 16'hFFFF represents one.
- R2: Insert output = sat(ami×m_up + aii×i_up).
- R3: Delete output = sat(amd×m_left + add×d_left).
- R4: The prior is 16'hFFFF−q_base when read_base equals hap_base, and q_base otherwise.
- R5: The transitions are derived as amm = 16'hFFFF−sat(q_ins+q_del), aim = adm = 16'hFFFF−q_gap, ami = q_ins, amd = q_del, aii = add = q_gap.
- R6: Boundary cells follow fixed values. With at_row0=1 and at_col0=1, the outputs are match=16'hFFFF, insert=0 and delete=0. With only at_col0=1, match and insert are 0 and delete follows R3. With only at_row0=1, match and delete are 0 and insert follows R2.
- R7: lik_out = sat(sat(m_out + i_out) + d_out) for the cell being presented.
- R8: Every sum clamps at 16'hFFFF and never wraps.
- R9: With USE_PARTIALS=1, the sum inside R1 is replaced by sat(part_a + part_b), and the three diagonal inputs have no effect. With USE_PARTIALS=0, part_a and part_b have no effect.
- R10: With out_ready held high, a cell accepted at a clock edge appears on out_valid after exactly DEPTH edges, and at most DEPTH cells are ever in flight.
- R11: After reset, out_valid is 0 and in_ready is 1. While out_valid=1 and out_ready=0, in_ready is 0 and every output holds its value.
- R12: out_tag returns the in_tag of the same cell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Cell presented |
| in_ready | output | 1 | Cell taken at this edge when valid |
| in_tag | input | TAG_W | Opaque context tag |
| read_base | input | BASE_W | Read base code |
| hap_base | input | BASE_W | Haplotype base code |
| q_base | input | 16 | Base error probability |
| q_ins | input | 16 | Insertion gap-open probability |
| q_del | input | 16 | Deletion gap-open probability |
| q_gap | input | 16 | Gap continuation probability |
| m_diag | input | 16 | Match value at (i-1,j-1) |
| i_diag | input | 16 | Insert value at (i-1,j-1) |
| d_diag | input | 16 | Delete value at (i-1,j-1) |
| m_up | input | 16 | Match value at (i-1,j) |
| i_up | input | 16 | Insert value at (i-1,j) |
| m_left | input | 16 | Match value at (i,j-1) |
| d_left | input | 16 | Delete value at (i,j-1) |
| part_a | input | 16 | Retimed partial term amm×m_diag |
| part_b | input | 16 | Retimed partial term sat(aim×i_diag + adm×d_diag) |
| at_row0 | input | 1 | Cell lies in row 0 |
| at_col0 | input | 1 | Cell lies in column 0 |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_tag | output | TAG_W | Tag of the result |
| m_out | output | 16 | New match value |
| i_out | output | 16 | New insert value |
| d_out | output | 16 | New delete value |
| lik_out | output | 16 | Saturated sum of the three values |

## Verification
The table vectors cover several cases: matching and mismatching bases, small and large quality values, nonzero values in each of the neighbour groups taken one at a time, each boundary flag, and inputs large enough to make the sums clamp. Between them these cases separate the prior selection, the transition arithmetic, each of the three recursions and the boundary overrides. Every vector drives both variants side by side. The retimed instance receives correct partial terms but corrupted diagonal values, and the direct instance receives junk partial terms. Agreement of both with the model therefore shows that each one ignores the inputs it must ignore. Directed cases compare against hand-worked values. They also stall the output to test the hold rules and time the gap from acceptance to delivery.

// File: rtl/phmm_pkg.sv
package phmm_pkg;
  parameter int PROB_W = 16;
  typedef logic [PROB_W-1:0] prob_t;

  // boundary class; encoding is {row0, col0}
  typedef enum logic [1:0] {
    BND_NONE   = 2'b00,
    BND_COL0   = 2'b01,
    BND_ROW0   = 2'b10,
    BND_ORIGIN = 2'b11
  } bnd_e;

  // truncating fractional product: keep upper half
  function automatic prob_t qmul(input prob_t a, input prob_t b);
    logic [2*PROB_W-1:0] p;
    p = a * b;
    return p[2*PROB_W-1:PROB_W];
  endfunction

  // saturating sum, clamps at all-ones
  function automatic prob_t qadd(input prob_t a, input prob_t b);
    logic [PROB_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PROB_W] ? '1 : s[PROB_W-1:0];
  endfunction
endpackage

// File: rtl/phmm_coef.sv
module phmm_coef
  import phmm_pkg::*;
#(
  parameter int BASE_W = 2
) (
  input  logic [BASE_W-1:0] read_base,
  input  logic [BASE_W-1:0] hap_base,
  input  prob_t             q_base,
  input  prob_t             q_ins,
  input  prob_t             q_del,
  input  prob_t             q_gap,
  output prob_t             prior,
  output prob_t             t_mm,
  output prob_t             t_im,
  output prob_t             t_dm,
  output prob_t             t_mi,
  output prob_t             t_ii,
  output prob_t             t_md,
  output prob_t             t_dd
);
  // 1 - x is the ones' complement, since all-ones stands for one
  always_comb begin
    prior = (read_base == hap_base) ? ~q_base : q_base;
    t_mm  = ~qadd(q_ins, q_del);
    t_im  = ~q_gap;
    t_dm  = ~q_gap;
    t_mi  = q_ins;
    t_md  = q_del;
    t_ii  = q_gap;
    t_dd  = q_gap;
  end
endmodule

// File: rtl/phmm_delay.sv
module phmm_delay #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic [N-1:0] v_q;
  logic [W-1:0] d_q [N];

  for (genvar g = 0; g < N; g++) begin : g_stage
    logic         v_src;
    logic [W-1:0] d_src;
    if (g == 0) begin : g_head
      assign v_src = in_v;
      assign d_src = in_d;
    end else begin : g_link
      assign v_src = v_q[g-1];
      assign d_src = d_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[g] <= 1'b0;
        d_q[g] <= '0;
      end else if (en) begin
        v_q[g] <= v_src;
        d_q[g] <= d_src;
      end
    end
  end

  assign out_v = v_q[N-1];
  assign out_d = d_q[N-1];
endmodule

// File: rtl/phmm_fwd_cell.sv
module phmm_fwd_cell
  import phmm_pkg::*;
#(
  parameter int BASE_W       = 2,
  parameter int TAG_W        = 4,
  parameter int DEPTH        = 4,   // at least 2
  parameter int USE_PARTIALS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [BASE_W-1:0] read_base,
  input  logic [BASE_W-1:0] hap_base,
  input  logic [15:0]       q_base,
  input  logic [15:0]       q_ins,
  input  logic [15:0]       q_del,
  input  logic [15:0]       q_gap,
  input  logic [15:0]       m_diag,
  input  logic [15:0]       i_diag,
  input  logic [15:0]       d_diag,
  input  logic [15:0]       m_up,
  input  logic [15:0]       i_up,
  input  logic [15:0]       m_left,
  input  logic [15:0]       d_left,
  input  logic [15:0]       part_a,
  input  logic [15:0]       part_b,
  input  logic              at_row0,
  input  logic              at_col0,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [15:0]       m_out,
  output logic [15:0]       i_out,
  output logic [15:0]       d_out,
  output logic [15:0]       lik_out
);
  localparam int TAIL  = DEPTH - 1;
  localparam int PAY_W = TAG_W + 4 * PROB_W;

  // whole pipeline moves together when the output slot frees
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // ---- stage A: coefficients and products ----
  prob_t prior_n, t_mm, t_im, t_dm, t_mi, t_ii, t_md, t_dd;
  prob_t sa_n, sb_n;

  phmm_coef #(.BASE_W(BASE_W)) u_coef (
    .read_base(read_base), .hap_base(hap_base),
    .q_base(q_base), .q_ins(q_ins), .q_del(q_del), .q_gap(q_gap),
    .prior(prior_n), .t_mm(t_mm), .t_im(t_im), .t_dm(t_dm),
    .t_mi(t_mi), .t_ii(t_ii), .t_md(t_md), .t_dd(t_dd)
  );

  if (USE_PARTIALS != 0) begin : g_retimed
    // partial terms come from the previous cell; diagonals unused
    logic unused_diag;
    assign unused_diag = ^{m_diag, i_diag, d_diag, t_mm, t_im, t_dm};
    assign sa_n = part_a;
    assign sb_n = part_b;
  end else begin : g_direct
    logic unused_part;
    assign unused_part = ^{part_a, part_b};
    assign sa_n = qmul(t_mm, m_diag);
    assign sb_n = qadd(qmul(t_im, i_diag), qmul(t_dm, d_diag));
  end

  logic             a_v;
  logic [TAG_W-1:0] a_tag;
  bnd_e             a_bnd;
  prob_t            a_prior, a_sa, a_sb, a_mi, a_ii, a_md, a_dd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_v     <= 1'b0;
      a_tag   <= '0;
      a_bnd   <= BND_NONE;
      a_prior <= '0;
      a_sa    <= '0;
      a_sb    <= '0;
      a_mi    <= '0;
      a_ii    <= '0;
      a_md    <= '0;
      a_dd    <= '0;
    end else if (adv) begin
      a_v     <= in_valid;
      a_tag   <= in_tag;
      a_bnd   <= bnd_e'({at_row0, at_col0});
      a_prior <= prior_n;
      a_sa    <= sa_n;
      a_sb    <= sb_n;
      a_mi    <= qmul(t_mi, m_up);
      a_ii    <= qmul(t_ii, i_up);
      a_md    <= qmul(t_md, m_left);
      a_dd    <= qmul(t_dd, d_left);
    end
  end

  // ---- stage B: sums, prior, boundary, likelihood ----
  prob_t m_raw, i_raw, d_raw, m_b, i_b, d_b, l_b;

  always_comb begin
    m_raw = qmul(a_prior, qadd(a_sa, a_sb));
    i_raw = qadd(a_mi, a_ii);
    d_raw = qadd(a_md, a_dd);
    unique case (a_bnd)
      BND_ORIGIN: begin m_b = '1; i_b = '0;    d_b = '0;    end
      BND_COL0:   begin m_b = '0; i_b = '0;    d_b = d_raw; end
      BND_ROW0:   begin m_b = '0; i_b = i_raw; d_b = '0;    end
      default:    begin m_b = m_raw; i_b = i_raw; d_b = d_raw; end
    endcase
    l_b = qadd(qadd(m_b, i_b), d_b);
  end

  // ---- remaining DEPTH-1 registers ----
  logic [PAY_W-1:0] pay_out;

  phmm_delay #(.W(PAY_W), .N(TAIL)) u_tail (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .in_v(a_v), .in_d({a_tag, m_b, i_b, d_b, l_b}),
    .out_v(out_valid), .out_d(pay_out)
  );

  assign {out_tag, m_out, i_out, d_out, lik_out} = pay_out;
endmodule

// File: rtl/phmm_fwd_cell_chk.sv
module phmm_fwd_cell_chk #(
  parameter int TAG_W = 4,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TAG_W-1:0] out_tag,
  input logic [15:0]      m_out,
  input logic [15:0]      i_out,
  input logic [15:0]      d_out,
  input logic [15:0]      lik_out
);
  localparam int CW = $clog2(DEPTH + 2) + 1;
  logic [CW-1:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
  end

  // R10: pipeline never holds more than DEPTH cells
  p_inflight_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(DEPTH));

  // R11: stalled output keeps every field and blocks input
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(m_out) && $stable(i_out)
      && $stable(d_out) && $stable(lik_out) && $stable(out_tag)));

  p_stall_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R11: empty output slot always accepts
  p_empty_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7: saturated sum dominates each component
  p_lik_dominates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lik_out >= m_out && lik_out >= i_out && lik_out >= d_out));
endmodule

bind phmm_fwd_cell phmm_fwd_cell_chk #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
  .m_out(m_out), .i_out(i_out), .d_out(d_out), .lik_out(lik_out)
);

// File: tb/test_phmm_fwd_cell.sv
module test_phmm_fwd_cell;
  import phmm_pkg::*;

  localparam int DEPTH = 4;

  typedef struct packed {
    logic [1:0] rb, hb;
    prob_t qb, qi, qd, qg, md, id, dd, mu, iu, ml, dl;
    logic r0, c0;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 16'h0100, 16'h0200, 16'h0300, 16'h1000, 16'h8000, 16'h2000, 16'h1000, 16'h4000, 16'h3000, 16'h5000, 16'h0800, 1'b0, 1'b0, 4'h1},
    '{2'd1, 2'd2, 16'h0400, 16'h0800, 16'h0100, 16'h2000, 16'hC000, 16'h1111, 16'h2222, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'h2},
    '{2'd3, 2'd3, 16'h2000, 16'h4000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h7777, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'h3},
    '{2'd2, 2'd2, 16'h0010, 16'h0000, 16'h6000, 16'h3000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hABCD, 16'h9000, 1'b0, 1'b0, 4'h4},
    '{2'd0, 2'd1, 16'hF000, 16'h9000, 16'h9000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 4'h5},
    '{2'd1, 2'd1, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h6000, 16'h6000, 16'h6000, 16'h6000, 16'h6000, 16'h6000, 16'h6000, 1'b1, 1'b1, 4'h6},
    '{2'd2, 2'd0, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h6000, 16'h6000, 16'h6000, 16'h7000, 16'h6000, 16'h8000, 16'h6000, 1'b0, 1'b1, 4'h7},
    '{2'd3, 2'd3, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h6000, 16'h6000, 16'h6000, 16'h7000, 16'h6000, 16'h8000, 16'h6000, 1'b1, 1'b0, 4'h8},
    '{2'd0, 2'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'hF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [3:0] in_tag = '0;
  logic [1:0] read_base = '0, hap_base = '0;
  prob_t q_base = '0, q_ins = '0, q_del = '0, q_gap = '0;
  prob_t m_diag = '0, i_diag = '0, d_diag = '0, m_up = '0, i_up = '0, m_left = '0, d_left = '0;
  prob_t pt_a = '0, pt_b = '0;
  logic at_row0 = 1'b0, at_col0 = 1'b0;

  logic in_ready, out_valid, p_in_ready, p_out_valid;
  logic [3:0] out_tag, p_out_tag;
  prob_t m_out, i_out, d_out, lik_out, pm_out, pi_out, pd_out, pl_out;

  phmm_fwd_cell #(.DEPTH(DEPTH), .USE_PARTIALS(0)) i_phmm_fwd_cell (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
    .read_base(read_base), .hap_base(hap_base), .q_base(q_base), .q_ins(q_ins),
    .q_del(q_del), .q_gap(q_gap), .m_diag(m_diag), .i_diag(i_diag), .d_diag(d_diag),
    .m_up(m_up), .i_up(i_up), .m_left(m_left), .d_left(d_left),
    .part_a(16'hDEAD), .part_b(16'hBEEF), .at_row0(at_row0), .at_col0(at_col0),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .m_out(m_out), .i_out(i_out), .d_out(d_out), .lik_out(lik_out)
  );

  // retimed variant: correct partials, corrupted diagonals (R9)
  phmm_fwd_cell #(.DEPTH(DEPTH), .USE_PARTIALS(1)) i_phmm_fwd_cell_pt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(p_in_ready), .in_tag(in_tag),
    .read_base(read_base), .hap_base(hap_base), .q_base(q_base), .q_ins(q_ins),
    .q_del(q_del), .q_gap(q_gap), .m_diag(~m_diag), .i_diag(~i_diag), .d_diag(m_diag ^ 16'h5A5A),
    .m_up(m_up), .i_up(i_up), .m_left(m_left), .d_left(d_left),
    .part_a(pt_a), .part_b(pt_b), .at_row0(at_row0), .at_col0(at_col0),
    .out_valid(p_out_valid), .out_ready(out_ready), .out_tag(p_out_tag),
    .m_out(pm_out), .i_out(pi_out), .d_out(pd_out), .lik_out(pl_out)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic prob_t mq(input prob_t a, input prob_t b);
    logic [31:0] p;
    p = {16'h0, a} * {16'h0, b};
    return p[31:16];
  endfunction

  function automatic prob_t aq(input prob_t a, input prob_t b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > 17'h0FFFF) ? 16'hFFFF : s[15:0];
  endfunction

  task automatic model(input vec_t v, output prob_t em, output prob_t ei, output prob_t ed,
                       output prob_t el, output prob_t ta, output prob_t tb);
    prob_t pr, amm, agm;
    pr  = (v.rb == v.hb) ? 16'hFFFF - v.qb : v.qb;
    amm = 16'hFFFF - aq(v.qi, v.qd);
    agm = 16'hFFFF - v.qg;
    ta  = mq(amm, v.md);
    tb  = aq(mq(agm, v.id), mq(agm, v.dd));
    em  = mq(pr, aq(ta, tb));
    ei  = aq(mq(v.qi, v.mu), mq(v.qg, v.iu));
    ed  = aq(mq(v.qd, v.ml), mq(v.qg, v.dl));
    if (v.r0 && v.c0) begin em = 16'hFFFF; ei = 0; ed = 0; end
    else if (v.c0) begin em = 0; ei = 0; end
    else if (v.r0) begin em = 0; ed = 0; end
    el = aq(aq(em, ei), ed);
  endtask

  task automatic drive(input vec_t v);
    prob_t em, ei, ed, el, ta, tb;
    model(v, em, ei, ed, el, ta, tb);
    read_base = v.rb; hap_base = v.hb; q_base = v.qb; q_ins = v.qi; q_del = v.qd;
    q_gap = v.qg; m_diag = v.md; i_diag = v.id; d_diag = v.dd; m_up = v.mu;
    i_up = v.iu; m_left = v.ml; d_left = v.dl; at_row0 = v.r0; at_col0 = v.c0;
    in_tag = v.tag; pt_a = ta; pt_b = tb;
  endtask

  // send one cell, return edges until out_valid (R10)
  task automatic send(input vec_t v, output int lat);
    @(negedge clk);
    drive(v);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    prob_t em, ei, ed, el, ta, tb, hm;
    vec_t hv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset out_valid", 32'(out_valid), 32'd0);
    chk("R11 reset in_ready", 32'(in_ready), 32'd1);

    // table walk: R1..R9 R12 against the model, both variants
    for (int k = 0; k < NV; k++) begin
      model(VECS[k], em, ei, ed, el, ta, tb);
      send(VECS[k], lat);
      chk("R10 latency", 32'(lat), 32'(DEPTH));
      chk("R1 R4 R5 R6 match", 32'(m_out), 32'(em));
      chk("R2 R6 R8 insert", 32'(i_out), 32'(ei));
      chk("R3 R6 R8 delete", 32'(d_out), 32'(ed));
      chk("R7 likelihood", 32'(lik_out), 32'(el));
      chk("R12 tag", 32'(out_tag), 32'(VECS[k].tag));
      chk("R9 retimed match", 32'(pm_out), 32'(em));
      chk("R9 retimed likelihood", 32'(pl_out), 32'(el));
      chk("R9 retimed valid", 32'(p_out_valid), 32'd1);
    end

    // R1 hand value: perfect match prior, m_diag = one half
    hv = '{2'd1, 2'd1, 16'h0, 16'h0, 16'h0, 16'h0, 16'h8000, 16'h0, 16'h0,
           16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 4'hA};
    send(hv, lat);
    chk("R1 hand match", 32'(m_out), 32'h7FFE);
    // R4 hand value: mismatch uses q_base directly
    hv = '{2'd0, 2'd3, 16'h4000, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0, 16'h0,
           16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 4'hB};
    send(hv, lat);
    chk("R4 hand mismatch", 32'(m_out), 32'h3FFF);
    // R8 clamp: insert sum FFFE+FFFE stays FFFF
    hv = '{2'd0, 2'd0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 16'h0, 16'h0,
           16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 1'b0, 1'b0, 4'hC};
    send(hv, lat);
    chk("R8 clamp insert", 32'(i_out), 32'hFFFF);
    chk("R8 clamp likelihood", 32'(lik_out), 32'hFFFF);
    // R6 origin hand value
    hv = '{2'd0, 2'd0, 16'h1234, 16'h1, 16'h1, 16'h1, 16'h1, 16'h1, 16'h1,
           16'h1, 16'h1, 16'h1, 16'h1, 1'b1, 1'b1, 4'hD};
    send(hv, lat);
    chk("R6 origin match", 32'(m_out), 32'hFFFF);
    chk("R6 origin insert", 32'(i_out), 32'h0);

    // R11 back-pressure: hold result while out_ready low
    @(negedge clk);
    out_ready = 1'b0;
    model(VECS[0], em, ei, ed, el, ta, tb);
    send(VECS[0], lat);
    chk("R10 latency under stall", 32'(lat), 32'(DEPTH));
    hm = m_out;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11 held valid", 32'(out_valid), 32'd1);
      chk("R11 held match", 32'(m_out), 32'(hm));
      chk("R11 input blocked", 32'(in_ready), 32'd0);
    end
    chk("R11 held value correct", 32'(m_out), 32'(em));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 drained", 32'(out_valid), 32'd0);
    chk("R11 ready again", 32'(in_ready), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule